// File: doc/BRIEF.md
# Wake-up event flag controller

This block gathers seven hardware event sources of a small 4-bit controller into one 8-bit sticky flag register. The sources are a divider overflow, underflows of two timers, value changes on two input ports, and the ends of speech and melody playback. Playback ends are seen as the falling edge of each engine's busy line. Software clears flags by nibble operations, and every flag is cleared whenever the core takes an interrupt.

A separately written 8-bit enable mask selects which events may bring the core out of its low-power hold state. While the hold input is high, an event whose enable bit is set raises a one-cycle wake request. The same edge latches the set of enabled events that caused the release into a release-condition register, which keeps that value until the next release.

Top module: `wake_evt_ctrl`

## Requirements
- R1: Flag bit positions are fixed: 0 divider overflow, 1 timer 0 underflow, 2 port C change, 3 port D change, 5 speech end, 6 melody end, 7 timer 1 underflow. A source active in a cycle sets its flag at the next clock edge.
- R2: A speech or melody end is a high-to-low transition of `spch_busy` or `mel_busy` between consecutive clock samples. A rising or steady busy line sets nothing. The previous busy value is 0 after reset.
- R3: A port flag is set when any bit of the port differs from its value sampled at the previous clock edge. The previous value is 0 after reset.
- R4: Flags stay set until cleared. A low-nibble clear (`flg_lo_clr_we`) clears each flag bit 3..0 whose `flg_lo_clr_mask` bit is 1.
- R5: A high-nibble move (`flg_hi_mov_we`) makes flag bits 7..4 equal to their old value ANDed with `flg_hi_mov_data`. A 0 clears the bit and a 1 keeps it.
- R6: `irq_taken` clears all eight flags at the next clock edge.
- R7: When a source sets a flag in the same cycle that a clear or an interrupt clears it, the flag ends up set.
- R8: Bit 4 of `flags` and of `enables` always reads 0, whatever is written.
- R9: `en_byte_we` loads all eight enable bits from `en_byte_data`. `en_lo_we` and `en_hi_we` load bits 3..0 and 7..4 from `en_nib_data`. When a byte write and a nibble write happen in the same cycle, the byte write wins.
- R10: `wake_req` goes high for one cycle on the edge after a cycle in which `hold_active` is 1 and an event occurs whose enable bit (the value before that edge) is 1. It is never high in two consecutive cycles.
- R11: `rel_cond` is loaded with the enabled events of that cycle on the same edge that raises `wake_req`, and holds its value at all other times.
- R12: After reset, flags, enables, rel_cond and wake_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ovf | input | 1 | Divider overflow strobe |
| tmr0_unf | input | 1 | Timer 0 underflow strobe |
| tmr1_unf | input | 1 | Timer 1 underflow strobe |
| port_c | input | PORT_W | Input port C value |
| port_d | input | PORT_W | Input port D value |
| spch_busy | input | 1 | Speech engine busy |
| mel_busy | input | 1 | Melody engine busy |
| irq_taken | input | 1 | Interrupt accepted by the core, clears all flags |
| flg_lo_clr_we | input | 1 | Low-nibble flag clear strobe |
| flg_lo_clr_mask | input | 4 | Flag bits 3..0 to clear |
| flg_hi_mov_we | input | 1 | High-nibble flag move strobe |
| flg_hi_mov_data | input | 4 | AND mask for flag bits 7..4 |
| en_byte_we | input | 1 | Full enable write strobe |
| en_byte_data | input | 8 | Full enable value |
| en_lo_we | input | 1 | Enable low-nibble write strobe |
| en_hi_we | input | 1 | Enable high-nibble write strobe |
| en_nib_data | input | 4 | Enable nibble value |
| hold_active | input | 1 | Core is in hold mode |
| flags | output | 8 | Event flag register |
| enables | output | 8 | Hold-release enable mask |
| rel_cond | output | 8 | Enabled events that caused the last release |
| wake_req | output | 1 | One-cycle hold release request |

## Verification
Directed patterns drive each source alone, so each flag's bit position is shown apart from the others. The busy lines are driven with rises, steady levels and falls to separate edge detection from level detection. Single-bit and multi-bit port changes show that every port bit reaches the compare. Clear, move and interrupt operations are applied alone and together with a colliding event, which shows whether set beats clear. Hold scenarios run with enabled and masked events and with events on back-to-back cycles, which tests the one-cycle pulse and the latching of the release condition. A long random phase then mixes all inputs against the reference model.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int FLG_W     = 8;
  localparam int NIB_W     = 4;
  localparam int B_DIV     = 0;
  localparam int B_TMR0    = 1;
  localparam int B_PC      = 2;
  localparam int B_PD      = 3;
  localparam int B_RSV     = 4;
  localparam int B_SPCH    = 5;
  localparam int B_MEL     = 6;
  localparam int B_TMR1    = 7;
  localparam logic [FLG_W-1:0] LIVE_MASK = ~(FLG_W'(1) << B_RSV);

  // place the raw sources on their fixed bit positions
  function automatic logic [FLG_W-1:0] pack_events(
    input logic div, input logic t0, input logic pc, input logic pd,
    input logic sp, input logic ml, input logic t1);
    logic [FLG_W-1:0] v;
    v         = '0;
    v[B_DIV]  = div;
    v[B_TMR0] = t0;
    v[B_PC]   = pc;
    v[B_PD]   = pd;
    v[B_SPCH] = sp;
    v[B_MEL]  = ml;
    v[B_TMR1] = t1;
    return v;
  endfunction

  // clear vector built from the software operations and the interrupt
  function automatic logic [FLG_W-1:0] clear_vec(
    input logic irq, input logic lo_we, input logic [NIB_W-1:0] lo_mask,
    input logic hi_we, input logic [NIB_W-1:0] hi_data);
    logic [FLG_W-1:0] c;
    if (irq) c = '1;
    else     c = {(hi_we ? ~hi_data : '0), (lo_we ? lo_mask : '0)};
    return c;
  endfunction

  // next flags: clear first, then events, so a set always survives
  function automatic logic [FLG_W-1:0] next_flags(
    input logic [FLG_W-1:0] cur, input logic [FLG_W-1:0] ev,
    input logic [FLG_W-1:0] clr);
    return ((cur & ~clr) | ev) & LIVE_MASK;
  endfunction
endpackage

// File: rtl/wk_edge_det.sv
module wk_edge_det #(
  parameter int W         = 4,
  parameter bit FALL_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic         hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  generate
    if (FALL_ONLY) begin : g_fall
      assign hit = |(prev_q & ~cur);
    end else begin : g_change
      assign hit = |(prev_q ^ cur);
    end
  endgenerate
endmodule

// File: rtl/wk_flag_reg.sv
module wk_flag_reg
  import wk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_W-1:0] evt_vec,
  input  logic [FLG_W-1:0] clr_vec,
  output logic [FLG_W-1:0] flags
);
  logic [FLG_W-1:0] flg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= next_flags(flg_q, evt_vec, clr_vec);
  end

  assign flags = flg_q;
endmodule

// File: rtl/wk_en_reg.sv
module wk_en_reg
  import wk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_we,
  input  logic [FLG_W-1:0] byte_data,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [NIB_W-1:0] nib_data,
  output logic [FLG_W-1:0] enables
);
  logic [FLG_W-1:0] en_q;
  logic [FLG_W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (byte_we) begin
      en_d = byte_data;
    end else begin
      if (lo_we) en_d[NIB_W-1:0]     = nib_data;
      if (hi_we) en_d[FLG_W-1:NIB_W] = nib_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d & LIVE_MASK;
  end

  assign enables = en_q;
endmodule

// File: rtl/wk_release.sv
module wk_release
  import wk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_active,
  input  logic [FLG_W-1:0] evt_vec,
  input  logic [FLG_W-1:0] enables,
  output logic             rel_hit,
  output logic             wake_req,
  output logic [FLG_W-1:0] rel_cond
);
  logic [FLG_W-1:0] armed;
  logic             wake_q;
  logic [FLG_W-1:0] cond_q;

  assign armed   = evt_vec & enables;
  assign rel_hit = hold_active & (|armed) & ~wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      cond_q <= '0;
    end else begin
      wake_q <= rel_hit;
      if (rel_hit) cond_q <= armed;
    end
  end

  assign wake_req = wake_q;
  assign rel_cond = cond_q;
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wk_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_ovf,
  input  logic              tmr0_unf,
  input  logic              tmr1_unf,
  input  logic [PORT_W-1:0] port_c,
  input  logic [PORT_W-1:0] port_d,
  input  logic              spch_busy,
  input  logic              mel_busy,
  input  logic              irq_taken,
  input  logic              flg_lo_clr_we,
  input  logic [3:0]        flg_lo_clr_mask,
  input  logic              flg_hi_mov_we,
  input  logic [3:0]        flg_hi_mov_data,
  input  logic              en_byte_we,
  input  logic [7:0]        en_byte_data,
  input  logic              en_lo_we,
  input  logic              en_hi_we,
  input  logic [3:0]        en_nib_data,
  input  logic              hold_active,
  output logic [7:0]        flags,
  output logic [7:0]        enables,
  output logic [7:0]        rel_cond,
  output logic              wake_req
);
  logic             pc_chg, pd_chg, spch_end, mel_end;
  logic [FLG_W-1:0] evt_vec;
  logic [FLG_W-1:0] clr_vec;
  logic             rel_hit;

  wk_edge_det #(.W(PORT_W), .FALL_ONLY(1'b0)) u_pc_det (
    .clk(clk), .rst_n(rst_n), .cur(port_c), .hit(pc_chg));
  wk_edge_det #(.W(PORT_W), .FALL_ONLY(1'b0)) u_pd_det (
    .clk(clk), .rst_n(rst_n), .cur(port_d), .hit(pd_chg));
  wk_edge_det #(.W(1), .FALL_ONLY(1'b1)) u_spch_det (
    .clk(clk), .rst_n(rst_n), .cur(spch_busy), .hit(spch_end));
  wk_edge_det #(.W(1), .FALL_ONLY(1'b1)) u_mel_det (
    .clk(clk), .rst_n(rst_n), .cur(mel_busy), .hit(mel_end));

  assign evt_vec = pack_events(div_ovf, tmr0_unf, pc_chg, pd_chg,
                               spch_end, mel_end, tmr1_unf);
  assign clr_vec = clear_vec(irq_taken, flg_lo_clr_we, flg_lo_clr_mask,
                             flg_hi_mov_we, flg_hi_mov_data);

  wk_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .clr_vec(clr_vec),
    .flags(flags));

  wk_en_reg u_en (
    .clk(clk), .rst_n(rst_n), .byte_we(en_byte_we), .byte_data(en_byte_data),
    .lo_we(en_lo_we), .hi_we(en_hi_we), .nib_data(en_nib_data),
    .enables(enables));

  wk_release u_rel (
    .clk(clk), .rst_n(rst_n), .hold_active(hold_active), .evt_vec(evt_vec),
    .enables(enables), .rel_hit(rel_hit), .wake_req(wake_req),
    .rel_cond(rel_cond));
endmodule

// File: rtl/wk_evt_chk.sv
module wk_evt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] evt_vec,
  input logic       rel_hit,
  input logic       hold_active,
  input logic       irq_taken,
  input logic [7:0] flags,
  input logic [7:0] enables,
  input logic [7:0] rel_cond,
  input logic       wake_req
);
  // R8
  rsv_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[4] == 1'b0) && (enables[4] == 1'b0));

  // R7
  set_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & 8'hEF) != 8'h00) |=>
      ((flags & $past(evt_vec & 8'hEF)) == $past(evt_vec & 8'hEF)));

  // R6
  irq_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && evt_vec == 8'h00) |=> (flags == 8'h00));

  // R10
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  // R10
  wake_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & enables) != 8'h00 && hold_active && !wake_req) |=> wake_req);

  // R10
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(hold_active));

  // R11
  cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_req |-> $stable(rel_cond));

  // R11
  cond_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit |=> (rel_cond != 8'h00));
endmodule

bind wake_evt_ctrl wk_evt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .rel_hit(rel_hit),
  .hold_active(hold_active), .irq_taken(irq_taken), .flags(flags),
  .enables(enables), .rel_cond(rel_cond), .wake_req(wake_req));

// File: tb/wake_evt_ctrl_bench.sv
`timescale 1ns/1ps
module wake_evt_ctrl_bench;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_ovf = 0, tmr0_unf = 0, tmr1_unf = 0;
  logic [PW-1:0] port_c = '0, port_d = '0;
  logic spch_busy = 0, mel_busy = 0, irq_taken = 0;
  logic flg_lo_clr_we = 0; logic [3:0] flg_lo_clr_mask = '0;
  logic flg_hi_mov_we = 0; logic [3:0] flg_hi_mov_data = '0;
  logic en_byte_we = 0; logic [7:0] en_byte_data = '0;
  logic en_lo_we = 0, en_hi_we = 0; logic [3:0] en_nib_data = '0;
  logic hold_active = 0;
  logic [7:0] flags, enables, rel_cond;
  logic wake_req;

  always #4 clk = ~clk;

  wake_evt_ctrl #(.PORT_W(PW)) u_wake_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .div_ovf(div_ovf), .tmr0_unf(tmr0_unf),
    .tmr1_unf(tmr1_unf), .port_c(port_c), .port_d(port_d),
    .spch_busy(spch_busy), .mel_busy(mel_busy), .irq_taken(irq_taken),
    .flg_lo_clr_we(flg_lo_clr_we), .flg_lo_clr_mask(flg_lo_clr_mask),
    .flg_hi_mov_we(flg_hi_mov_we), .flg_hi_mov_data(flg_hi_mov_data),
    .en_byte_we(en_byte_we), .en_byte_data(en_byte_data),
    .en_lo_we(en_lo_we), .en_hi_we(en_hi_we), .en_nib_data(en_nib_data),
    .hold_active(hold_active), .flags(flags), .enables(enables),
    .rel_cond(rel_cond), .wake_req(wake_req));

  // reference state
  int m_flags = 0, m_en = 0, m_cond = 0, m_wake = 0;
  int p_c = 0, p_d = 0, p_sp = 0, p_ml = 0;
  int vectors = 0, miscompares = 0;
  string tag = "R12";
  bit finished = 0;

  task automatic cmp(string what, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    vectors++;
    cmp("flags", int'(flags), m_flags);
    cmp("enables", int'(enables), m_en);
    cmp("rel_cond", int'(rel_cond), m_cond);
    cmp("wake_req", int'(wake_req), m_wake);
  endtask

  // behavioural reference of one clock edge
  task automatic model_edge();
    int ev = 0;
    int nf, ne, hit;
    if (div_ovf) ev += 1;
    if (tmr0_unf) ev += 2;
    if (int'(port_c) != p_c) ev += 4;
    if (int'(port_d) != p_d) ev += 8;
    if (p_sp == 1 && spch_busy == 0) ev += 32;
    if (p_ml == 1 && mel_busy == 0) ev += 64;
    if (tmr1_unf) ev += 128;
    nf = m_flags;
    if (irq_taken) nf = 0;
    else begin
      for (int i = 0; i < 4; i++)
        if (flg_lo_clr_we && flg_lo_clr_mask[i]) nf &= ~(1 << i);
      for (int i = 4; i < 8; i++)
        if (flg_hi_mov_we && !flg_hi_mov_data[i-4]) nf &= ~(1 << i);
    end
    nf = (nf | ev) & 'hEF;
    ne = m_en;
    if (en_byte_we) ne = int'(en_byte_data);
    else begin
      if (en_lo_we) ne = (ne & 'hF0) | int'(en_nib_data);
      if (en_hi_we) ne = (ne & 'h0F) | (int'(en_nib_data) << 4);
    end
    ne &= 'hEF;
    hit = (hold_active && (ev & m_en) != 0 && m_wake == 0) ? 1 : 0;
    if (hit == 1) m_cond = ev & m_en;
    m_wake = hit;
    m_flags = nf;
    m_en = ne;
    p_c = int'(port_c); p_d = int'(port_d);
    p_sp = int'(spch_busy); p_ml = int'(mel_busy);
  endtask

  task automatic idle_inputs();
    div_ovf = 0; tmr0_unf = 0; tmr1_unf = 0; irq_taken = 0;
    flg_lo_clr_we = 0; flg_hi_mov_we = 0;
    en_byte_we = 0; en_lo_we = 0; en_hi_we = 0;
  endtask

  // at the falling edge: compare, then the caller drives, then model_edge
  task automatic settle();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic commit();
    model_edge();
  endtask

  task automatic cyc();
    settle();
    commit();
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R12: reset state
    tag = "R12";
    compare_all();
    rst_n = 1;
    cyc();

    // R1: each strobe source alone
    tag = "R1";
    settle(); div_ovf = 1; commit();
    settle(); tmr0_unf = 1; commit();
    settle(); tmr1_unf = 1; commit();
    cyc();
    // R6: interrupt clears everything
    tag = "R6";
    settle(); irq_taken = 1; commit();
    cyc();

    // R3: port changes, single and multi bit
    tag = "R3";
    settle(); port_c = 4'b0100; commit();
    cyc();
    settle(); port_d = 4'b1001; commit();
    cyc();
    settle(); port_d = 4'b1001; commit();
    // R4: low nibble clear by mask
    tag = "R4";
    settle(); flg_lo_clr_we = 1; flg_lo_clr_mask = 4'b0100; commit();
    cyc();
    settle(); flg_lo_clr_we = 1; flg_lo_clr_mask = 4'b1111; commit();
    cyc();

    // R2: busy rise / steady / fall
    tag = "R2";
    settle(); spch_busy = 1; mel_busy = 1; commit();
    cyc(); cyc();
    settle(); spch_busy = 0; commit();
    cyc();
    settle(); mel_busy = 0; commit();
    cyc();
    // R5: high nibble move
    tag = "R5";
    settle(); tmr1_unf = 1; commit();
    settle(); flg_hi_mov_we = 1; flg_hi_mov_data = 4'b1101; commit();
    cyc();
    settle(); flg_hi_mov_we = 1; flg_hi_mov_data = 4'b0000; commit();
    cyc();

    // R7: set vs clear collision
    tag = "R7";
    settle(); div_ovf = 1; commit();
    settle(); div_ovf = 1; flg_lo_clr_we = 1; flg_lo_clr_mask = 4'hF; commit();
    settle(); tmr1_unf = 1; irq_taken = 1; commit();
    settle(); tmr1_unf = 1; flg_hi_mov_we = 1; flg_hi_mov_data = 4'h0; commit();
    cyc();

    // R9: enable writes
    tag = "R9";
    settle(); en_byte_we = 1; en_byte_data = 8'hA5; commit();
    settle(); en_lo_we = 1; en_nib_data = 4'h3; commit();
    settle(); en_hi_we = 1; en_nib_data = 4'hC; commit();
    settle(); en_byte_we = 1; en_byte_data = 8'h0F; en_hi_we = 1; en_lo_we = 1;
      en_nib_data = 4'hF; commit();
    // R8: reserved bit writes ignored
    tag = "R8";
    settle(); en_byte_we = 1; en_byte_data = 8'hFF; commit();
    settle(); en_hi_we = 1; en_nib_data = 4'h1; commit();
    cyc();

    // R10: hold release, masked and enabled events
    tag = "R10";
    settle(); en_byte_we = 1; en_byte_data = 8'h82; commit();
    settle(); hold_active = 1; div_ovf = 1; commit();
    cyc();
    settle(); tmr0_unf = 1; commit();
    settle(); tmr0_unf = 1; commit();
    settle(); tmr0_unf = 1; tmr1_unf = 1; commit();
    cyc();
    settle(); hold_active = 0; tmr1_unf = 1; commit();
    cyc();
    // R11: condition latched and held
    tag = "R11";
    settle(); hold_active = 1; tmr1_unf = 1; commit();
    cyc(); cyc();
    settle(); hold_active = 0; commit();

    // R1: mixed random traffic against the model
    tag = "R1";
    for (int k = 0; k < 3000; k++) begin
      settle();
      div_ovf  = ($urandom_range(0, 7) == 0);
      tmr0_unf = ($urandom_range(0, 7) == 0);
      tmr1_unf = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 5) == 0) port_c = PW'($urandom);
      if ($urandom_range(0, 5) == 0) port_d = PW'($urandom);
      if ($urandom_range(0, 3) == 0) spch_busy = ~spch_busy;
      if ($urandom_range(0, 3) == 0) mel_busy = ~mel_busy;
      irq_taken = ($urandom_range(0, 15) == 0);
      flg_lo_clr_we = ($urandom_range(0, 7) == 0);
      flg_lo_clr_mask = 4'($urandom);
      flg_hi_mov_we = ($urandom_range(0, 7) == 0);
      flg_hi_mov_data = 4'($urandom);
      en_byte_we = ($urandom_range(0, 15) == 0);
      en_byte_data = 8'($urandom);
      en_lo_we = ($urandom_range(0, 15) == 0);
      en_hi_we = ($urandom_range(0, 15) == 0);
      en_nib_data = 4'($urandom);
      hold_active = ($urandom_range(0, 2) != 0);
      commit();
    end
    settle();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule